// File: doc/BRIEF.md
# Fixed-Point Word-Length Reducer

This block shortens an unsigned fixed-point word of three integer bits and thirteen fractional bits to a ten-bit word. The result keeps all three integer bits and the top seven fractional bits. A one-bit mode input chooses the reduction method:

- **Truncation** drops the low fractional bits.
- **Symmetric rounding** adds half of an output LSB before dropping them.

Alongside the shortened value the block reports the residual error, in units of the input LSB (2^-13). It also raises a flag when rounding would carry out of the integer field; in that case the output saturates.

The arithmetic is combinational. With the default build, results are captured into an output register on a rising clock edge when `in_valid` is high. A two-state control machine drives `out_valid`:

- **ST_IDLE**: no new result this cycle.
- **ST_FRESH**: the registered outputs were loaded at the last edge.

The machine has two transitions:

- It moves to ST_FRESH from either state whenever `in_valid` is sampled high.
- It moves to ST_IDLE from either state whenever `in_valid` is sampled low.

Top module: `fxr_reducer`

## Requirements
- R1: While `rst_n` is low, and after its release until the first accepted input, `out_valid`, `res`, `err` and `ovf` are all zero.
- R2: With `mode` = 0 (truncate), `res` equals `in_data[15:6]` and `ovf` is 0.
- R3: With `mode` = 1 (round), `res` equals `in_data[15:6]` plus `in_data[5]` (the 2^-8 bit) when that sum fits in 10 bits.
- R4: In round mode, a discarded part of exactly one half LSB (`in_data[5:0]` = 6'b100000) rounds up, away from zero.
- R5: In round mode, if `in_data[15:6]` is all ones and `in_data[5]` is 1, `res` is 10'h3FF and `ovf` is 1. In truncate mode `ovf` is always 0.
- R6: In truncate mode `err` equals the discarded bits `in_data[5:0]`, read as an unsigned count of 2^-13.
- R7: In round mode `err` is the exact input minus `res`, as a 6-bit two's-complement count of 2^-13 (range -32..+31). On overflow `err` is clamped to +31 (6'b011111).
- R8: The outputs load on the rising edge at which `in_valid` is high. `out_valid` is high for exactly the cycle that follows each such edge and low after an edge with `in_valid` low.
- R9: While `in_valid` is low, changes on `in_data` or `mode` leave `res`, `err` and `ovf` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word is valid; load the outputs |
| mode | input | 1 | 0 = truncate, 1 = symmetric round |
| in_data | input | 16 | Unsigned input, 3 integer + 13 fractional bits |
| out_valid | output | 1 | High for one cycle after an accepted input |
| res | output | 10 | Reduced value, 3 integer + 7 fractional bits |
| err | output | 6 | Exact input minus `res`, in units of 2^-13 |
| ovf | output | 1 | Rounding overflowed; `res` is saturated |

## Verification
The bench builds the block with its default parameters: three integer bits, thirteen input fractional bits, seven output fractional bits, and the output register present. This makes the six-bit discarded field small enough that its boundary patterns can be listed directly: zero, just below half, exactly half, just above half, and all ones. Those patterns are applied in both modes, together with the all-ones and just-below-all-ones kept fields where a rounding carry reaches the integer MSB or saturates. The registered build also brings the load timing, the one-cycle valid pulse and the hold behaviour under test.

// File: rtl/fxr_pkg.sv
package fxr_pkg;

    typedef enum logic {
        MODE_TRUNC = 1'b0,
        MODE_ROUND = 1'b1
    } red_mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FRESH = 1'b1
    } out_state_e;

endpackage

// File: rtl/fxr_slice.sv
// Splits the input word into the kept upper field and the discarded low field.
module fxr_slice #(
    parameter int IN_W   = 16,
    parameter int DROP_W = 6
) (
    input  logic [IN_W-1:0]        word,
    output logic [IN_W-DROP_W-1:0] kept,
    output logic [DROP_W-1:0]      drop
);
    localparam int KEEP_W = IN_W - DROP_W;

    generate
        if (KEEP_W < 1 || DROP_W < 1) begin : g_bad
            initial $fatal(1, "fxr_slice: field widths must both be positive");
        end
    endgenerate

    always_comb begin
        kept = word[IN_W-1 -: KEEP_W];
        drop = word[DROP_W-1:0];
    end

endmodule

// File: rtl/fxr_round.sv
// Applies truncation or half-LSB rounding, with saturation and residual error.
module fxr_round
    import fxr_pkg::*;
#(
    parameter int OUT_W  = 10,
    parameter int DROP_W = 6
) (
    input  red_mode_e         mode,
    input  logic [OUT_W-1:0]  kept,
    input  logic [DROP_W-1:0] drop,
    output logic [OUT_W-1:0]  res,
    output logic [DROP_W-1:0] err,
    output logic              ovf
);
    // Largest positive value of a DROP_W-bit two's-complement number.
    localparam logic [DROP_W-1:0] ERR_CLAMP = {1'b0, {(DROP_W-1){1'b1}}};

    logic             half_bit;
    logic [OUT_W:0]   sum;

    always_comb begin
        half_bit = (mode == MODE_ROUND) ? drop[DROP_W-1] : 1'b0;
        sum      = {1'b0, kept} + {{OUT_W{1'b0}}, half_bit};
        ovf      = sum[OUT_W];
        res      = ovf ? {OUT_W{1'b1}} : sum[OUT_W-1:0];
        // exact - res, modulo 2^DROP_W: res carries no weight below the output
        // LSB, so the low field alone gives the residual (negative after a
        // round-up, since the carried-in LSB exceeds the dropped part).
        if (ovf) begin
            err = ERR_CLAMP;
        end else begin
            err = drop;
        end
    end

endmodule

// File: rtl/fxr_reducer.sv
module fxr_reducer
    import fxr_pkg::*;
#(
    parameter int INT_W      = 3,
    parameter int IN_FRAC_W  = 13,
    parameter int OUT_FRAC_W = 7,
    parameter bit OUT_REG    = 1'b1,
    localparam int IN_W      = INT_W + IN_FRAC_W,
    localparam int OUT_W     = INT_W + OUT_FRAC_W,
    localparam int DROP_W    = IN_FRAC_W - OUT_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              mode,
    input  logic [IN_W-1:0]   in_data,
    output logic              out_valid,
    output logic [OUT_W-1:0]  res,
    output logic [DROP_W-1:0] err,
    output logic              ovf
);
    logic [OUT_W-1:0]  kept_w;
    logic [DROP_W-1:0] drop_w;
    logic [OUT_W-1:0]  res_w;
    logic [DROP_W-1:0] err_w;
    logic              ovf_w;
    red_mode_e         mode_e;

    assign mode_e = red_mode_e'(mode);

    fxr_slice #(
        .IN_W   (IN_W),
        .DROP_W (DROP_W)
    ) u_slice (
        .word (in_data),
        .kept (kept_w),
        .drop (drop_w)
    );

    fxr_round #(
        .OUT_W  (OUT_W),
        .DROP_W (DROP_W)
    ) u_round (
        .mode (mode_e),
        .kept (kept_w),
        .drop (drop_w),
        .res  (res_w),
        .err  (err_w),
        .ovf  (ovf_w)
    );

    generate
        if (OUT_REG) begin : g_reg
            out_state_e        state_q, state_d;
            logic [OUT_W-1:0]  res_q;
            logic [DROP_W-1:0] err_q;
            logic              ovf_q;

            always_comb begin
                unique case (state_q)
                    ST_IDLE:  state_d = in_valid ? ST_FRESH : ST_IDLE;
                    ST_FRESH: state_d = in_valid ? ST_FRESH : ST_IDLE;
                    default:  state_d = ST_IDLE;
                endcase
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    state_q <= ST_IDLE;
                end else begin
                    state_q <= state_d;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    res_q <= '0;
                    err_q <= '0;
                    ovf_q <= 1'b0;
                end else if (in_valid) begin
                    res_q <= res_w;
                    err_q <= err_w;
                    ovf_q <= ovf_w;
                end
            end

            always_comb begin
                out_valid = (state_q == ST_FRESH);
                res       = res_q;
                err       = err_q;
                ovf       = ovf_q;
            end
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk ^ rst_n;
            always_comb begin
                out_valid = in_valid;
                res       = res_w;
                err       = err_w;
                ovf       = ovf_w;
            end
        end
    endgenerate

endmodule

// File: rtl/fxr_reducer_chk.sv
module fxr_reducer_chk #(
    parameter int IN_W    = 16,
    parameter int OUT_W   = 10,
    parameter int DROP_W  = 6,
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              mode,
    input logic [IN_W-1:0]   in_data,
    input logic              out_valid,
    input logic [OUT_W-1:0]  res,
    input logic [DROP_W-1:0] err,
    input logic              ovf
);
    generate
        if (OUT_REG) begin : g_chk
            // R8
            p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            // R8
            p_valid_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            // R9
            p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> ($stable(res) && $stable(err) && $stable(ovf)));
            // R2
            p_trunc_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !mode) |=> (res == $past(in_data[IN_W-1 -: OUT_W])));
            // R6
            p_trunc_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !mode) |=> (err == $past(in_data[DROP_W-1:0])));
            // R5
            p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !mode) |=> !ovf);
            // R5
            p_sat_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
                ovf |-> (res == {OUT_W{1'b1}}));
        end
    endgenerate

endmodule

bind fxr_reducer fxr_reducer_chk #(
    .IN_W    (IN_W),
    .OUT_W   (OUT_W),
    .DROP_W  (DROP_W),
    .OUT_REG (OUT_REG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .in_data   (in_data),
    .out_valid (out_valid),
    .res       (res),
    .err       (err),
    .ovf       (ovf)
);

// File: tb/test_fxr_reducer.sv
`timescale 1ns/1ps
module test_fxr_reducer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        mode = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic [9:0]  res;
    logic [5:0]  err;
    logic        ovf;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    fxr_reducer i_fxr_reducer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .mode      (mode),
        .in_data   (in_data),
        .out_valid (out_valid),
        .res       (res),
        .err       (err),
        .ovf       (ovf)
    );

    // {mode, in_data, exp_res, exp_err, exp_ovf}
    localparam int NV = 13;
    localparam logic [33:0] VEC [NV] = '{
        {1'b0, 16'h661E, 10'h198, 6'h1E, 1'b0}, // R2 R6 worked example
        {1'b1, 16'h661E, 10'h198, 6'h1E, 1'b0}, // R3 R7 below half
        {1'b0, 16'h0000, 10'h000, 6'h00, 1'b0}, // R2 zero
        {1'b1, 16'h0020, 10'h001, 6'h20, 1'b0}, // R4 tie rounds up, err -32
        {1'b1, 16'h001F, 10'h000, 6'h1F, 1'b0}, // R3 just below half
        {1'b1, 16'h003F, 10'h001, 6'h3F, 1'b0}, // R7 err -1
        {1'b0, 16'hFFFF, 10'h3FF, 6'h3F, 1'b0}, // R5 R6 truncate never ovf
        {1'b1, 16'hFFFF, 10'h3FF, 6'h1F, 1'b1}, // R5 R7 saturate
        {1'b1, 16'hFFE0, 10'h3FF, 6'h1F, 1'b1}, // R4 R5 tie at top
        {1'b1, 16'hFFDF, 10'h3FF, 6'h1F, 1'b0}, // R5 no carry at top
        {1'b1, 16'h8060, 10'h202, 6'h20, 1'b0}, // R3 R4
        {1'b0, 16'h8060, 10'h201, 6'h20, 1'b0}, // R2 R6
        {1'b1, 16'h7FE0, 10'h200, 6'h20, 1'b0}  // R3 carry into integer MSB
    };

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1", "out_valid", {15'd0, out_valid}, 16'd0);
        check("R1", "res", {6'd0, res}, 16'd0);
        check("R1", "err/ovf", {9'd0, err, ovf}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "res after release", {6'd0, res}, 16'd0);
        check("R1", "out_valid after release", {15'd0, out_valid}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            mode     = VEC[i][33];
            in_data  = VEC[i][32:17];
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check("R8", "out_valid", {15'd0, out_valid}, 16'd1);
            check("R2/R3", "res", {6'd0, res}, {6'd0, VEC[i][16:7]});
            check("R6/R7", "err", {10'd0, err}, {10'd0, VEC[i][6:1]});
            check("R5", "ovf", {15'd0, ovf}, {15'd0, VEC[i][0]});
        end

        // R9: inputs change with in_valid low; last result (R3 0x7FE0) stays
        mode    = 1'b0;
        in_data = 16'hFFFF;
        @(negedge clk);
        check("R8", "out_valid low", {15'd0, out_valid}, 16'd0);
        check("R9", "res held", {6'd0, res}, 16'h200);
        check("R9", "err held", {10'd0, err}, 16'h20);
        mode    = 1'b1;
        @(negedge clk);
        check("R9", "ovf held", {15'd0, ovf}, 16'd0);

        // R8: back-to-back accepts keep out_valid high
        in_valid = 1'b1;
        mode     = 1'b1;
        in_data  = 16'hFFFF;
        @(negedge clk);
        check("R5", "ovf set", {15'd0, ovf}, 16'd1);
        mode    = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8", "out_valid back-to-back", {15'd0, out_valid}, 16'd1);
        check("R5", "truncate clears ovf", {15'd0, ovf}, 16'd0);
        @(negedge clk);
        check("R8", "out_valid falls", {15'd0, out_valid}, 16'd0);

        // R1: reset mid-run clears outputs
        rst_n = 1'b0;
        #1;
        check("R1", "async clear", {5'd0, res, ovf}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule